// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is the shift datapath of a small 16-bit processor. It takes one register value, a 4-bit shift count and a 5-bit extended operation code. It returns the shifted or rotated word together with fresh negative, zero and carry flags. The register file writes the result back into the same register it was read from. The flag logic stores the new flags and hands the stored carry back on the next shift.

The unit is purely combinational. Any count from 0 to 15 settles within one cycle, because the word passes through one conditional stage for each bit of the count. Five extended codes pick a mode. Any other code passes the word through unchanged.

Top module: `shf_unit`

## Requirements
- R1: Extended code 2 (logical right) returns the value shifted right by the count, with zeros filling the vacated top bits.
- R2: Extended code 3 (arithmetic right) returns the value shifted right by the count, with bit 15 copied into every vacated top bit.
- R3: Extended code 4 (left shift) returns the value shifted left by the count, with zeros filling the vacated low bits.
- R4: Extended code 5 (rotate left) moves bits circularly within 16 bits toward the top. Bit 15 re-enters at bit 0, and the incoming carry never enters the word.
- R5: Extended code 6 (rotate right) moves bits circularly within 16 bits toward the bottom. Bit 0 re-enters at bit 15, and the incoming carry never enters the word.
- R6: For a nonzero count, carry out is the last bit pushed off the word. For codes 2 and 3 this is value bit count-1. For code 4 it is value bit 16-count.
- R7: For a nonzero count on a rotate, carry out is the last bit that wrapped around. For code 5 this is result bit 0. For code 6 it is result bit 15.
- R8: A count of 0 returns the value unchanged and carry out equals carry in, for every code.
- R9: Negative out always equals result bit 15. Zero out is 1 exactly when the result is 0x0000.
- R10: Any extended code other than 2 to 6 returns the value unchanged and carry out equals carry in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value_i | input | 16 | Register value to shift or rotate |
| count_i | input | 4 | Shift or rotate distance, 0 to 15 |
| xop_i | input | 5 | Extended operation code |
| c_i | input | 1 | Current carry flag |
| result_o | output | 16 | Shifted or rotated word |
| n_o | output | 1 | New negative flag |
| z_o | output | 1 | New zero flag |
| c_o | output | 1 | New carry flag |

## Verification
The bench targets the extremes of the count.

With a count of 0, a design that still takes a carry from the word would clobber the saved carry. With a count of 15, the carry index lands at the far end of the word, and a design using 16-count or count-1 in the wrong mode would pick the neighbouring bit. Words with bit 15 set separate the arithmetic shift from the logical one, because a unit that confuses them fills the top with the wrong bit.

Rotates are driven with carry in set against a cleared word. A unit that threads the carry through the rotation would then show a stray 1. Unlisted codes are checked to come out as a plain pass-through.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
// Package shf_pkg
// Purpose : shared widths and the internal mode encoding of the shifter.
// Assumes : the word width is a power of two, so the count width is log2.
package shf_pkg;
    localparam int WORD_W  = 16;
    localparam int CNT_W   = $clog2(WORD_W);
    localparam int XOP_W   = 5;

    // Extended operation codes as they appear in the instruction.
    localparam logic [XOP_W-1:0] XOP_LSR = 5'd2;
    localparam logic [XOP_W-1:0] XOP_ASR = 5'd3;
    localparam logic [XOP_W-1:0] XOP_LSL = 5'd4;
    localparam logic [XOP_W-1:0] XOP_ROL = 5'd5;
    localparam logic [XOP_W-1:0] XOP_ROR = 5'd6;

    typedef enum logic [2:0] {
        M_PASS = 3'd0,
        M_LSR  = 3'd1,
        M_ASR  = 3'd2,
        M_LSL  = 3'd3,
        M_ROL  = 3'd4,
        M_ROR  = 3'd5
    } shf_mode_e;
endpackage

// File: rtl/shf_decode.sv
`timescale 1ns/1ps
// Module shf_decode
// Purpose : turns the extended operation code into an internal mode.
// Assumes : unlisted codes must act as a pass-through (no shift, carry kept).
module shf_decode
    import shf_pkg::*;
#(
    parameter int XW = XOP_W
) (
    input  logic [XW-1:0] xop_i,
    output shf_mode_e     mode_o
);
    // Map each recognised code to its mode; everything else passes through.
    always_comb begin
        unique case (xop_i)
            XOP_LSR: mode_o = M_LSR;
            XOP_ASR: mode_o = M_ASR;
            XOP_LSL: mode_o = M_LSL;
            XOP_ROL: mode_o = M_ROL;
            XOP_ROR: mode_o = M_ROR;
            default: mode_o = M_PASS;
        endcase
    end
endmodule

// File: rtl/shf_barrel.sv
`timescale 1ns/1ps
// Module shf_barrel
// Purpose : logarithmic shifter/rotator; stage k moves the word by 2**k
//           when count bit k is set, and records the last bit moved out.
// Assumes : W is a power of two and CW = log2(W); because every stage's
//           carry refers to the already-shifted word, the carry of the last
//           active stage equals the last bit out of the whole operation.
module shf_barrel
    import shf_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [CW-1:0] amt_i,
    input  shf_mode_e     mode_i,
    input  logic          c_i,
    output logic [W-1:0]  data_o,
    output logic          c_o
);
    localparam int STAGES = CW;

    // Walk the stages in order, each one conditionally moving by 2**k.
    always_comb begin
        logic [W-1:0] cur;
        logic         cy;
        cur = data_i;
        cy  = c_i;
        for (int k = 0; k < STAGES; k++) begin
            if (amt_i[k]) begin
                case (mode_i)
                    M_LSR: begin
                        cy  = cur[(1 << k) - 1];
                        cur = cur >> (1 << k);
                    end
                    M_ASR: begin
                        cy  = cur[(1 << k) - 1];
                        cur = $unsigned($signed(cur) >>> (1 << k));
                    end
                    M_LSL: begin
                        cy  = cur[W - (1 << k)];
                        cur = cur << (1 << k);
                    end
                    M_ROL: begin
                        cy  = cur[W - (1 << k)];
                        cur = (cur << (1 << k)) | (cur >> (W - (1 << k)));
                    end
                    M_ROR: begin
                        cy  = cur[(1 << k) - 1];
                        cur = (cur >> (1 << k)) | (cur << (W - (1 << k)));
                    end
                    default: begin
                        cur = cur;
                        cy  = cy;
                    end
                endcase
            end
        end
        data_o = cur;
        c_o    = cy;
    end
endmodule

// File: rtl/shf_flags.sv
`timescale 1ns/1ps
// Module shf_flags
// Purpose : derives negative and zero flags from the final word.
// Assumes : flags follow every operation, including count 0 and pass-through.
module shf_flags #(
    parameter int W = 16
) (
    input  logic [W-1:0] res_i,
    output logic         n_o,
    output logic         z_o
);
    // Sign bit and all-zero detect of the result.
    always_comb begin
        n_o = res_i[W-1];
        z_o = (res_i == '0);
    end
endmodule

// File: rtl/shf_unit.sv
`timescale 1ns/1ps
// Module shf_unit
// Purpose : top of the shift/rotate unit; decode, barrel and flag stages.
// Assumes : fully combinational, one pass per instruction; the caller holds
//           the flag register and feeds the stored carry back in on c_i.
module shf_unit
    import shf_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = $clog2(W),
    parameter int XW = XOP_W
) (
    input  logic [W-1:0]  value_i,
    input  logic [CW-1:0] count_i,
    input  logic [XW-1:0] xop_i,
    input  logic          c_i,
    output logic [W-1:0]  result_o,
    output logic          n_o,
    output logic          z_o,
    output logic          c_o
);
    shf_mode_e mode;

    shf_decode #(.XW(XW)) u_dec (
        .xop_i  (xop_i),
        .mode_o (mode)
    );

    shf_barrel #(.W(W), .CW(CW)) u_bar (
        .data_i (value_i),
        .amt_i  (count_i),
        .mode_i (mode),
        .c_i    (c_i),
        .data_o (result_o),
        .c_o    (c_o)
    );

    shf_flags #(.W(W)) u_flg (
        .res_i (result_o),
        .n_o   (n_o),
        .z_o   (z_o)
    );

    // Port-level checks guarding the barrel output against the mode rules.
    always_comb begin
        if (!$isunknown({value_i, count_i, xop_i, c_i})) begin
            // R8
            zero_count_chk: assert (count_i != '0 || (result_o == value_i && c_o == c_i));
            // R10
            pass_code_chk: assert (mode != M_PASS || (result_o == value_i && c_o == c_i));
            // R1
            lsr_topfill_chk: assert (mode != M_LSR || count_i == '0 || !result_o[W-1]);
            // R2
            asr_sign_chk: assert (mode != M_ASR || result_o[W-1] == value_i[W-1]);
            // R3
            lsl_lowfill_chk: assert (mode != M_LSL || count_i == '0 || !result_o[0]);
            // R4
            rol_keep_chk: assert (mode != M_ROL || $countones(result_o) == $countones(value_i));
            // R5
            ror_keep_chk: assert (mode != M_ROR || $countones(result_o) == $countones(value_i));
            // R7
            rol_carry_chk: assert (mode != M_ROL || count_i == '0 || c_o == result_o[0]);
            // R7
            ror_carry_chk: assert (mode != M_ROR || count_i == '0 || c_o == result_o[W-1]);
            // R6
            lsr_carry_chk: assert (mode != M_LSR || count_i == '0 || c_o == value_i[count_i - 1'b1]);
        end
    end
endmodule

// File: tb/sim_shf_unit.sv
`timescale 1ns/1ps
// Bench sim_shf_unit: drives vectors on the rising edge, compares against a
// bit-serial behavioural model on the falling edge.
module sim_shf_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] value;
    logic [3:0]  count;
    logic [4:0]  xop;
    logic        cin;
    logic [15:0] result;
    logic        n, z, cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    shf_unit u0 (
        .value_i  (value),
        .count_i  (count),
        .xop_i    (xop),
        .c_i      (cin),
        .result_o (result),
        .n_o      (n),
        .z_o      (z),
        .c_o      (cout)
    );

    // One bit at a time, as many times as the count says.
    task automatic model(input logic [15:0] v, input int cnt, input int op,
                         input logic ci, output logic [15:0] r, output logic c);
        r = v;
        c = ci;
        if (op < 2 || op > 6) return;
        for (int i = 0; i < cnt; i++) begin
            case (op)
                2: begin c = r[0];  r = {1'b0, r[15:1]}; end
                3: begin c = r[0];  r = {r[15], r[15:1]}; end
                4: begin c = r[15]; r = {r[14:0], 1'b0}; end
                5: begin c = r[15]; r = {r[14:0], r[15]}; end
                default: begin c = r[0]; r = {r[0], r[15:1]}; end
            endcase
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (v=%h cnt=%0d op=%0d ci=%0b)",
                     tag, act, exp, value, count, xop, cin);
        end
    endtask

    task automatic run(input logic [15:0] v, input int cnt, input int op, input logic ci);
        logic [15:0] er;
        logic        ec;
        string       rtag, ctag;
        @(posedge clk);
        value = v; count = cnt[3:0]; xop = op[4:0]; cin = ci;
        model(v, cnt, op, ci, er, ec);
        @(negedge clk);
        if (op < 2 || op > 6) begin rtag = "R10"; ctag = "R10"; end
        else if (cnt == 0)    begin rtag = "R8";  ctag = "R8";  end
        else begin
            case (op)
                2: rtag = "R1";
                3: rtag = "R2";
                4: rtag = "R3";
                5: rtag = "R4";
                default: rtag = "R5";
            endcase
            ctag = (op >= 5) ? "R7" : "R6";
        end
        check(rtag, int'(result), int'(er));
        check(ctag, int'(cout), int'(ec));
        check("R9", int'({n, z}), int'({er[15], er == 16'h0}));
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        value = '0; count = '0; xop = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: all-zero inputs give a zero word with z set (R9, R10).
        check("R10", int'(result), 0);
        check("R9", int'({n, z, cout}), 3'b010);

        // Boundary counts for every mode, sign-bit words, carry in both ways.
        for (int op = 2; op <= 6; op++) begin
            run(16'h8001, 0, op, 1'b1);
            run(16'h8001, 1, op, 1'b0);
            run(16'h8001, 15, op, 1'b0);
            run(16'h7FFE, 15, op, 1'b1);
            run(16'h0000, 7, op, 1'b1);   // carry must not leak into word (R4, R5)
            run(16'hA5C3, 8, op, 1'b0);
        end
        // Unlisted codes pass through (R10).
        run(16'hBEEF, 5, 0, 1'b1);
        run(16'hBEEF, 9, 7, 1'b0);
        run(16'h1234, 15, 31, 1'b1);
        run(16'h8000, 3, 1, 1'b0);

        // Random sweep across all inputs.
        for (int i = 0; i < 3000; i++) begin
            run($urandom() & 16'hFFFF, $urandom_range(0, 15),
                $urandom_range(0, 31), $urandom_range(0, 1));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule